// File: doc/BRIEF.md
# I2C Register Pointer Target

This block is a target on a two-wire serial bus. It lets an external controller reach a small bank of 8-bit registers through a stored pointer. It runs on a fast system clock. That clock oversamples the bus clock and data lines through synchronizers, and an edge detector finds START, repeated START and STOP conditions. The block answers one fixed 7-bit address, and only pulls the data line low, through an output enable.

After the address with the write direction, the first byte sets the register pointer. Each later byte is written into the register that the pointer selects, and the pointer then steps by one. A read returns the register that the pointer selects, starting with the most significant bit. Each time the controller acknowledges a byte, the pointer steps on to the next register. The pointer keeps its value across transactions, so a read can skip the pointer phase. To read from a new location, the controller sets the pointer and then issues a repeated START. The register bank sits outside the block and is reached through a single-port parallel interface.

Top module: `i2c_ptr_target`

## Requirements
- R1: The block answers address 7'b1100000 by driving the data line low during the ninth clock of the address frame. With any other address it gives no acknowledge, never drives the line and writes nothing until the next START.
- R2: A fall of SDA while SCL is high is a START, and it always begins a new address frame, whatever the current state.
- R3: After the address with R/W = 0 (write), the first byte is acknowledged and its low log2(REG_COUNT) bits are loaded into the pointer.
- R4: Every byte after the pointer byte in a write is acknowledged. It is written, as one single-cycle write strobe, to the register the pointer selects, and the pointer then advances by one.
- R5: After the address with R/W = 1 (read), the block drives the selected register's bits, most significant first, starting in the clock right after its address acknowledge.
- R6: A controller ACK (SDA low in the ninth clock of a read frame) advances the pointer and sends the next register. A NACK (SDA high) leaves the pointer unchanged, releases the bus and ends the read.
- R7: The pointer keeps its value between transactions. A read with no pointer phase starts at the stored pointer.
- R8: A repeated START after a pointer byte begins a new address frame and writes no register.
- R9: The pointer wraps from REG_COUNT-1 to 0, on reads and on writes alike.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle at any point without changing the pointer. Reset leaves the pointer at 0 and the bus released.
- R11: The output enable of the data line changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when high |
| rf_we | output | 1 | Single-cycle write strobe to the register bank |
| rf_addr | output | log2(REG_COUNT) | Register bank address (the pointer) |
| rf_wdata | output | 8 | Write data to the register bank |
| rf_rdata | input | 8 | Read data from the register bank at rf_addr |

## Verification
The assertions take for granted that the controller follows bus rules. It changes SDA only while SCL is low, except to make START and STOP. It never makes a START or STOP while the target is holding SDA low. It keeps each SCL level for many system clocks, so that the synchronized edges arrive in order. The bench drives the bus only through tasks that hold each level for ten system clocks. It changes data only in the low phase, and it sends STOP or repeated START only after the target has released the line. Random transactions choose among writes, plain reads and pointer-set reads, with random pointers, lengths and data. Each result is compared with a register-bank model kept in the bench.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDATA,
      ST_RDATA,
      ST_SKIP
   } bus_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2ct_sync needs at least two stages");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d_in};
   end

   assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic cond_start,
   output logic cond_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise   = scl_s & ~scl_q;
   assign scl_fall   = ~scl_s & scl_q;
   assign cond_start = scl_s & scl_q & sda_q & ~sda_s;
   assign cond_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
   import i2ct_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1100000,
   parameter int         REG_COUNT   = 16,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW          = $clog2(REG_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          sda_oe,
   output logic          rf_we,
   output logic [AW-1:0] rf_addr,
   output logic [7:0]    rf_wdata,
   input  logic [7:0]    rf_rdata
);
   if (REG_COUNT < 2 || REG_COUNT > 256 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
      $error("REG_COUNT must be a power of two from 2 to 256");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, cond_start, cond_stop;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s));
   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));

   i2ct_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .cond_start(cond_start), .cond_stop(cond_stop));

   bus_state_e    state;
   logic [3:0]    bit_cnt;
   logic          in_ack, ack_drv, rd_first, ctl_nack, we_q;
   logic [7:0]    rx_sh, tx_sh, wdata_q;
   logic [AW-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         in_ack   <= 1'b0;
         ack_drv  <= 1'b0;
         rd_first <= 1'b0;
         ctl_nack <= 1'b0;
         we_q     <= 1'b0;
         rx_sh    <= '0;
         tx_sh    <= '1;
         wdata_q  <= '0;
         ptr      <= '0;
      end else begin
         we_q <= 1'b0;
         if (we_q) ptr <= ptr + 1'b1;
         if (cond_stop) begin
            state   <= ST_IDLE;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            bit_cnt <= '0;
         end else if (cond_start) begin
            state   <= ST_ADDR;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            bit_cnt <= '0;
         end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (scl_rise) begin
               if (!in_ack) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (state == ST_RDATA && !rd_first) begin
                  ctl_nack <= sda_s;
                  if (!sda_s) ptr <= ptr + 1'b1;
               end
            end else if (scl_fall) begin
               if (!in_ack) begin
                  if (bit_cnt == 4'd8) begin
                     in_ack  <= 1'b1;
                     bit_cnt <= '0;
                     case (state)
                        ST_ADDR: begin
                           if (rx_sh[7:1] == DEV_ADDR) begin
                              ack_drv  <= 1'b1;
                              rd_first <= 1'b1;
                              state    <= rx_sh[0] ? ST_RDATA : ST_PTR;
                           end else begin
                              state <= ST_SKIP;
                           end
                        end
                        ST_PTR: begin
                           ack_drv <= 1'b1;
                           ptr     <= rx_sh[AW-1:0];
                           state   <= ST_WDATA;
                        end
                        ST_WDATA: begin
                           ack_drv <= 1'b1;
                           we_q    <= 1'b1;
                           wdata_q <= rx_sh;
                        end
                        default: ack_drv <= 1'b0;
                     endcase
                  end else if (state == ST_RDATA) begin
                     tx_sh <= {tx_sh[6:0], 1'b1};
                  end
               end else begin
                  in_ack  <= 1'b0;
                  ack_drv <= 1'b0;
                  if (state == ST_RDATA) begin
                     if (!rd_first && ctl_nack) begin
                        state <= ST_SKIP;
                     end else begin
                        tx_sh    <= rf_rdata;
                        rd_first <= 1'b0;
                     end
                  end
               end
            end
         end
      end
   end

   assign sda_oe   = (in_ack & ack_drv) | (state == ST_RDATA & ~in_ack & ~tx_sh[7]);
   assign rf_we    = we_q;
   assign rf_addr  = ptr;
   assign rf_wdata = wdata_q;

   assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);
   assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cond_start |=> (state == ST_ADDR && bit_cnt == 4'd0));
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cond_stop |=> (state == ST_IDLE && $stable(ptr)));
   assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> rf_addr == $past(rf_addr) + 1'b1);
   assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SKIP |-> (!sda_oe && !rf_we));
   assert_no_write_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_PTR |-> !rf_we);
endmodule

// File: tb/tb_i2c_ptr_target.sv
module tb_i2c_ptr_target;
   localparam int HALF = 10;
   localparam int NREG = 16;

   logic clk = 1'b0, rst_n = 1'b0, ctl_scl = 1'b1, ctl_sda = 1'b1;
   logic sda_oe, rf_we;
   logic [3:0] rf_addr;
   logic [7:0] rf_wdata, rf_rdata;
   logic [7:0] mem [NREG];
   logic [7:0] exp_mem [NREG];
   int mptr = 0;
   int n_chk = 0, n_fail = 0, viol = 0;
   logic oe_prev = 1'b0;
   logic scl_in, sda_in;

   always #2 clk = ~clk;
   assign scl_in = ctl_scl;
   assign sda_in = ctl_sda & ~sda_oe;

   i2c_ptr_target dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_oe(sda_oe), .rf_we(rf_we), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

   function automatic logic [7:0] f_init(input int i);
      return 8'((i * 37 + 11) & 8'hFF);
   endfunction

   assign rf_rdata = mem[rf_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= f_init(i);
      end else if (rf_we) begin
         mem[rf_addr] <= rf_wdata;
      end
   end

   always @(posedge clk) begin
      if (rst_n && sda_oe !== oe_prev && ctl_scl) viol++;
      oe_prev <= sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      ctl_sda = 1'b1; tick(HALF);
      ctl_scl = 1'b1; tick(HALF);
      ctl_sda = 1'b0; tick(HALF);
      ctl_scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      ctl_sda = 1'b0; tick(HALF);
      ctl_scl = 1'b1; tick(HALF);
      ctl_sda = 1'b1; tick(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic a);
      for (int i = 7; i >= 0; i--) begin
         ctl_sda = b[i]; tick(HALF);
         ctl_scl = 1'b1; tick(HALF);
         ctl_scl = 1'b0;
      end
      ctl_sda = 1'b1; tick(HALF);
      ctl_scl = 1'b1; tick(HALF / 2);
      a = sda_oe;
      tick(HALF / 2);
      ctl_scl = 1'b0; tick(2);
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic nack);
      ctl_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(HALF);
         ctl_scl = 1'b1; tick(HALF / 2);
         b[i] = sda_in;
         tick(HALF / 2);
         ctl_scl = 1'b0;
      end
      ctl_sda = nack; tick(HALF);
      ctl_scl = 1'b1; tick(HALF);
      ctl_scl = 1'b0; tick(2);
   endtask

   task automatic cmp_mem(input string tag);
      for (int i = 0; i < NREG; i++) chk(mem[i] == exp_mem[i], tag, mem[i], exp_mem[i]);
   endtask

   task automatic do_write(input int p, input int n, input logic [7:0] d0, d1, d2);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(8'hC0, a); chk(a == 1'b1, "R1 R2 write address ack", a, 1);
      send_byte(8'(p), a); chk(a == 1'b1, "R3 pointer ack", a, 1);
      mptr = p % NREG;
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
         send_byte(d, a); chk(a == 1'b1, "R4 data ack", a, 1);
         exp_mem[mptr] = d;
         mptr = (mptr + 1) % NREG;
      end
      bus_stop(); tick(4);
      cmp_mem("R4 R9 register contents after write");
   endtask

   task automatic do_read(input bit set_ptr, input int p, input int n, input string tag);
      logic a;
      logic [7:0] b;
      if (set_ptr) begin
         bus_start();
         send_byte(8'hC0, a); chk(a == 1'b1, "R1 pointer-set address ack", a, 1);
         send_byte(8'(p), a); chk(a == 1'b1, "R3 pointer-set ack", a, 1);
         mptr = p % NREG;
      end
      bus_start();
      send_byte(8'hC1, a); chk(a == 1'b1, "R1 R8 read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(b, (k == n - 1));
         chk(b == exp_mem[mptr], tag, b, exp_mem[mptr]);
         if (k < n - 1) mptr = (mptr + 1) % NREG;
      end
      chk(sda_oe == 1'b0, "R6 bus released after NACK", sda_oe, 0);
      bus_stop(); tick(4);
      if (set_ptr) cmp_mem("R8 no write after repeated START");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic a;
      int op, p, n;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NREG; i++) exp_mem[i] = f_init(i);
      tick(6);
      rst_n = 1'b1;
      tick(4);
      chk(sda_oe == 1'b0, "R10 reset bus released", sda_oe, 0);
      chk(rf_we == 1'b0, "R10 reset no write", rf_we, 0);
      chk(rf_addr == 4'd0, "R10 reset pointer", rf_addr, 0);

      // R3 R4: pointer then three data bytes
      do_write(3, 3, 8'hA5, 8'h5A, 8'hC3);
      // R7 R5 R6: read without pointer phase, from stored pointer 6
      do_read(1'b0, 0, 2, "R7 R5 read from stored pointer");
      // R6: NACK left the pointer on the last byte read
      do_read(1'b0, 0, 1, "R6 pointer held after NACK");
      // R8 R9: pointer set, repeated START, read across the wrap
      do_read(1'b1, 14, 3, "R8 R9 read after repeated START with wrap");
      // R9: write across the wrap
      do_write(15, 2, 8'h3C, 8'h96, 8'h00);

      // R1: foreign address is ignored
      bus_start();
      send_byte(8'h62, a); chk(a == 1'b0, "R1 no ack for other address", a, 0);
      send_byte(8'h05, a); chk(a == 1'b0, "R1 no ack for ignored byte", a, 0);
      send_byte(8'h77, a); chk(a == 1'b0, "R1 no ack for ignored byte", a, 0);
      bus_stop(); tick(4);
      cmp_mem("R1 ignored transfer writes nothing");

      // R10: STOP after the pointer byte keeps the new pointer
      bus_start();
      send_byte(8'hC0, a); chk(a == 1'b1, "R1 address ack", a, 1);
      send_byte(8'h09, a); chk(a == 1'b1, "R3 pointer ack", a, 1);
      mptr = 9;
      bus_stop(); tick(4);
      chk(rf_addr == 4'd9, "R10 pointer after STOP", rf_addr, 9);
      // R10: STOP right after the address leaves the pointer unchanged
      bus_start();
      send_byte(8'hC0, a); chk(a == 1'b1, "R2 address ack after STOP", a, 1);
      bus_stop(); tick(4);
      do_read(1'b0, 0, 1, "R10 pointer kept across STOP");

      for (int it = 0; it < 24; it++) begin
         op = int'($urandom % 3);
         p  = int'($urandom % NREG);
         n  = 1 + int'($urandom % 3);
         case (op)
            0: do_write(p, n, 8'($urandom), 8'($urandom), 8'($urandom));
            1: do_read(1'b0, 0, n, "R5 R7 random read");
            default: do_read(1'b1, p, n, "R6 R8 random pointer read");
         endcase
      end

      chk(viol == 0, "R11 output enable changed while SCL high", viol, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule